// File: doc/BRIEF.md
# Instruction Prefetch Queue Unit

This block sits on the bus-interface side of a processor core. It keeps a short byte FIFO of upcoming instruction bytes filled ahead of the execution unit. Each fetch address is 20 bits wide. It is the 16-bit code segment shifted left by four bits plus the 16-bit fetch offset. The execution unit takes bytes from the head of the FIFO through a valid/ready pop port. The block shares one request/acknowledge memory port between its own prefetches and the execution unit's operand transfers, and the operand transfers always come first.

A refill starts only in a cycle where the bus is idle, at least two queue bytes are free and the execution unit is not asking for the bus. The queue holds six bytes on a 16-bit data bus and four bytes on an 8-bit data bus, selected by a parameter. After a control transfer the execution unit pulses a flush input. The flush empties the queue, discards the result of any fetch still in flight, and loads a new segment and offset for the next fetch.

Top module: `pfq_unit`

## Requirements
- R1: The queue holds 6 bytes when BUS16=1 and 4 bytes when BUS16=0. With no pops, filling an empty queue from an even offset on the 16-bit bus takes exactly three fetch acknowledges, after which no further fetch is issued.
- R2: A fetch drives mem_addr = (segment * 16 + offset) mod 2^20 with mem_we=0. After reset the segment is 16'hFFFF and the offset is 0, so the first fetch address is 20'hFFFF0.
- R3: A new fetch is launched only after a cycle in which the bus was idle, at most DEPTH-2 bytes were queued, eu_req was low and flush was low.
- R4: When the bus is idle and eu_req and a refill are both eligible in the same cycle, the next transaction is the execution-unit transfer, with mem_addr = eu_addr and mem_we = eu_we.
- R5: Once started, a transaction keeps mem_req high with a stable mem_addr until the cycle in which mem_ack is high. An execution-unit request raised during a fetch waits for that fetch to end.
- R6: Bytes leave the queue in the order they were fetched, and while q_valid is high and q_ready is low the head byte stays unchanged.
- R7: On the 16-bit bus, a fetch at an even offset queues mem_rdata[7:0] and then mem_rdata[15:8] and advances the offset by 2. A fetch at an odd offset queues only mem_rdata[15:8] and advances the offset by 1. On the 8-bit bus each fetch queues mem_rdata[7:0] and advances the offset by 1.
- R8: A flush makes q_valid low in the next cycle and drops the data of any fetch that is in flight or acknowledged in the flush cycle. The next fetch uses flush_seg and flush_off.
- R9: The offset wraps modulo 65536 and the 20-bit address sum wraps modulo 2^20. For example, segment 16'hFFFF with offset 16'hFFFE gives 20'h0FFEE, and the fetch after it uses offset 0.
- R10: q_valid is low exactly when the queue is empty. A push and a pop in the same cycle neither lose nor duplicate a byte.
- R11: eu_ack is high only when mem_ack is high during an execution-unit transaction, and mem_we follows the eu_we captured at launch.
- R12: rst_n asserts asynchronously. The block leaves reset on the second rising clock edge after rst_n rises, and during reset mem_req and q_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the queue and reload the fetch pointer |
| flush_seg | input | 16 | New code segment loaded on flush |
| flush_off | input | 16 | New fetch offset loaded on flush |
| eu_req | input | 1 | Execution unit requests the bus; held until eu_ack |
| eu_we | input | 1 | Execution-unit transfer is a write |
| eu_addr | input | 20 | Execution-unit transfer address |
| eu_ack | output | 1 | Execution-unit transfer completes this cycle |
| mem_req | output | 1 | Memory transaction active |
| mem_we | output | 1 | Memory transaction is a write |
| mem_addr | output | 20 | Memory transaction address |
| mem_ack | input | 1 | Memory completes the transaction this cycle |
| mem_rdata | input | 16 (BUS16=1) or 8 | Memory read data |
| q_valid | output | 1 | Head byte available |
| q_data | output | 8 | Head byte |
| q_ready | input | 1 | Execution unit pops the head byte |

## Verification
Two pairs of events can fall in the same cycle. One is an execution-unit request and a refill both becoming eligible on an idle bus. The other is a flush landing while a fetch is outstanding or on the very cycle it is acknowledged. The bench forces the first by flushing a full, idle queue and raising eu_req on the next cycle, and it then expects the execution-unit address on the bus. It provokes the second with a fixed long memory latency, a directed flush and random flushes under random latency. It judges the outcome by comparing every cycle against a byte-queue reference model, so the dropped bytes must never appear at q_data and the next fetch address must come from the new segment and offset.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_FETCH = 2'd1,
    OWN_EU    = 2'd2
  } bus_owner_e;

  localparam int SEG_SHIFT = 4;
  localparam int SEG_W     = 16;
  localparam int PADDR_W   = SEG_W + SEG_SHIFT;
endpackage

// File: rtl/pfq_addr.sv
module pfq_addr
  import pfq_pkg::*;
(
  input  logic [SEG_W-1:0]   seg,
  input  logic [SEG_W-1:0]   off,
  output logic [PADDR_W-1:0] phys
);
  // segment shifted left, offset zero-extended; sum truncated wraps mod 2^PADDR_W
  always_comb begin
    phys = {seg, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, off};
  end
endmodule

// File: rtl/pfq_fifo.sv
module pfq_fifo #(
  parameter int DEPTH = 6,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [1:0]    push_n,
  input  logic [7:0]    push_b0,
  input  logic [7:0]    push_b1,
  input  logic          pop,
  output logic [7:0]    head,
  output logic [CW-1:0] count
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [7:0]    store [DEPTH];
  logic [PW-1:0] rd_q, rd_d, wr_q, wr_d, wr_inc, wr_inc2;
  logic [CW-1:0] cnt_d;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    wr_inc  = ptr_inc(wr_q);
    wr_inc2 = ptr_inc(wr_inc);
    if (clr) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end else begin
      rd_d  = pop ? ptr_inc(rd_q) : rd_q;
      case (push_n)
        2'd1:    wr_d = wr_inc;
        2'd2:    wr_d = wr_inc2;
        default: wr_d = wr_q;
      endcase
      cnt_d = count + CW'(push_n) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      count <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      count <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic we0, we1;
    always_comb begin
      we0 = !clr && (push_n != 2'd0) && (wr_q == PW'(i));
      we1 = !clr && (push_n == 2'd2) && (wr_inc == PW'(i));
    end
    always_ff @(posedge clk) begin
      if (we0)      store[i] <= push_b0;
      else if (we1) store[i] <= push_b1;
    end
  end

  always_comb head = store[rd_q];
endmodule

// File: rtl/pfq_arb.sv
module pfq_arb
  import pfq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       eu_req,
  input  logic       fetch_ok,
  input  logic       mem_ack,
  output bus_owner_e owner,
  output logic       launch_eu,
  output logic       launch_fetch
);
  bus_owner_e owner_d;

  always_comb begin
    owner_d      = owner;
    launch_eu    = 1'b0;
    launch_fetch = 1'b0;
    if (owner == OWN_NONE) begin
      if (eu_req) begin
        owner_d   = OWN_EU;
        launch_eu = 1'b1;
      end else if (fetch_ok) begin
        owner_d      = OWN_FETCH;
        launch_fetch = 1'b1;
      end
    end else if (mem_ack) begin
      owner_d = OWN_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner <= OWN_NONE;
    else        owner <= owner_d;
  end
endmodule

// File: rtl/pfq_unit.sv
module pfq_unit
  import pfq_pkg::*;
#(
  parameter bit          BUS16   = 1'b1,
  parameter logic [15:0] RST_SEG = 16'hFFFF,
  parameter logic [15:0] RST_OFF = 16'h0000,
  localparam int DW    = BUS16 ? 16 : 8,
  localparam int DEPTH = BUS16 ? 6 : 4,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [SEG_W-1:0]   flush_seg,
  input  logic [SEG_W-1:0]   flush_off,
  input  logic               eu_req,
  input  logic               eu_we,
  input  logic [PADDR_W-1:0] eu_addr,
  output logic               eu_ack,
  output logic               mem_req,
  output logic               mem_we,
  output logic [PADDR_W-1:0] mem_addr,
  input  logic               mem_ack,
  input  logic [DW-1:0]      mem_rdata,
  output logic               q_valid,
  output logic [7:0]         q_data,
  input  logic               q_ready
);
  localparam logic [CW-1:0] FILL_MAX = CW'(DEPTH - 2);

  logic rs_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rs_meta    <= 1'b1;
      rst_sync_n <= rs_meta;
    end
  end

  logic [SEG_W-1:0]   seg_q, seg_d, off_q, off_d;
  logic               cancel_q, cancel_d, we_q, we_d;
  logic [PADDR_W-1:0] addr_q, addr_d, fetch_phys;
  logic               seg_en, off_en;
  bus_owner_e         owner_q;
  logic               launch_eu, launch_fetch, fetch_ok, ack_fetch, keep;
  logic [CW-1:0]      count;
  logic [1:0]         lane_n, push_n;
  logic [7:0]         lane_b0, lane_b1;
  logic               pop;

  pfq_addr u_addr (.seg(seg_q), .off(off_q), .phys(fetch_phys));

  always_comb fetch_ok = (count <= FILL_MAX) && !flush;

  pfq_arb u_arb (
    .clk(clk), .rst_n(rst_sync_n), .eu_req(eu_req), .fetch_ok(fetch_ok),
    .mem_ack(mem_ack), .owner(owner_q), .launch_eu(launch_eu),
    .launch_fetch(launch_fetch)
  );

  if (BUS16) begin : g_lane16
    always_comb begin
      if (off_q[0]) begin
        lane_n  = 2'd1;
        lane_b0 = mem_rdata[15:8];
        lane_b1 = mem_rdata[15:8];
      end else begin
        lane_n  = 2'd2;
        lane_b0 = mem_rdata[7:0];
        lane_b1 = mem_rdata[15:8];
      end
    end
  end else begin : g_lane8
    always_comb begin
      lane_n  = 2'd1;
      lane_b0 = mem_rdata[7:0];
      lane_b1 = mem_rdata[7:0];
    end
  end

  always_comb begin
    ack_fetch = (owner_q == OWN_FETCH) && mem_ack;
    keep      = ack_fetch && !cancel_q && !flush;
    push_n    = keep ? lane_n : 2'd0;
    q_valid   = (count != '0);
    pop       = q_ready && q_valid;
    seg_en    = flush;
    seg_d     = flush_seg;
    off_en    = flush || keep;
    off_d     = flush ? flush_off : off_q + SEG_W'(lane_n);
    if (flush && (owner_q == OWN_FETCH) && !mem_ack) cancel_d = 1'b1;
    else if (ack_fetch)                               cancel_d = 1'b0;
    else                                              cancel_d = cancel_q;
    if (launch_eu) begin
      addr_d = eu_addr;
      we_d   = eu_we;
    end else if (launch_fetch) begin
      addr_d = fetch_phys;
      we_d   = 1'b0;
    end else begin
      addr_d = addr_q;
      we_d   = we_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      seg_q    <= RST_SEG;
      off_q    <= RST_OFF;
      cancel_q <= 1'b0;
      addr_q   <= '0;
      we_q     <= 1'b0;
    end else begin
      if (seg_en) seg_q <= seg_d;
      if (off_en) off_q <= off_d;
      cancel_q <= cancel_d;
      addr_q   <= addr_d;
      we_q     <= we_d;
    end
  end

  pfq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_sync_n), .clr(flush), .push_n(push_n),
    .push_b0(lane_b0), .push_b1(lane_b1), .pop(pop), .head(q_data),
    .count(count)
  );

  always_comb begin
    mem_req  = (owner_q != OWN_NONE);
    mem_we   = we_q;
    mem_addr = addr_q;
    eu_ack   = mem_ack && (owner_q == OWN_EU);
  end
endmodule

// File: rtl/pfq_unit_chk.sv
module pfq_unit_chk
  import pfq_pkg::*;
#(
  parameter bit BUS16 = 1'b1,
  localparam int DEPTH = BUS16 ? 6 : 4,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic               eu_req,
  input logic               mem_req,
  input logic               mem_ack,
  input logic [PADDR_W-1:0] mem_addr,
  input logic               q_valid,
  input logic               q_ready,
  input logic [7:0]         q_data,
  input logic [CW-1:0]      count,
  input bus_owner_e         owner
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R1

  AST_FETCH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_FETCH && $past(owner) == OWN_NONE) |->
      ($past(count) <= CW'(DEPTH - 2) && !$past(eu_req) && !$past(flush))); // R3

  AST_EU_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_NONE && eu_req) |=> (owner == OWN_EU)); // R4

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R5

  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !q_ready && !flush) |=> (q_valid && $stable(q_data))); // R6

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !q_valid); // R8
endmodule

bind pfq_unit pfq_unit_chk #(.BUS16(BUS16)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .flush(flush), .eu_req(eu_req),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .q_valid(q_valid), .q_ready(q_ready), .q_data(q_data),
  .count(count), .owner(owner_q)
);

// File: tb/pfq_unit_tb_top.sv
`timescale 1ns/1ps
module pfq_unit_tb_top;
  localparam int M_DEPTH = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [15:0] flush_seg = '0, flush_off = '0;
  logic        eu_req = 1'b0, eu_we = 1'b0;
  logic [19:0] eu_addr = '0;
  logic        eu_ack, mem_req, mem_we;
  logic [19:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        q_valid;
  logic [7:0]  q_data;
  logic        q_ready = 1'b0;

  always #2.5 clk = ~clk;

  pfq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .flush_seg(flush_seg),
    .flush_off(flush_off), .eu_req(eu_req), .eu_we(eu_we), .eu_addr(eu_addr),
    .eu_ack(eu_ack), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .q_valid(q_valid),
    .q_data(q_data), .q_ready(q_ready)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_at(logic [19:0] a);
    return a[7:0] ^ {a[19:16], a[11:8]} ^ 8'h3C;
  endfunction

  // reference model state
  bit [7:0]    mq[$];
  int          m_owner;   // 0 idle, 1 fetch, 2 execution unit
  logic [19:0] m_addr;
  bit          m_we, m_cancel;
  logic [15:0] m_seg, m_off;
  bit          mr1, mr2;

  task automatic model_reset();
    mq.delete();
    m_owner  = 0;
    m_addr   = '0;
    m_we     = 1'b0;
    m_cancel = 1'b0;
    m_seg    = 16'hFFFF;
    m_off    = 16'h0000;
  endtask

  task automatic model_step();
    int  nfree = M_DEPTH - mq.size();
    int  old   = m_owner;
    bit  ackf  = (m_owner == 1) && mem_ack;
    bit  popv  = q_ready && (mq.size() > 0);
    bit  keep  = ackf && !m_cancel && !flush;
    if (popv) void'(mq.pop_front());
    if (keep) begin
      if (m_off[0]) begin
        mq.push_back(mem_rdata[15:8]);
        m_off = m_off + 16'd1;
      end else begin
        mq.push_back(mem_rdata[7:0]);
        mq.push_back(mem_rdata[15:8]);
        m_off = m_off + 16'd2;
      end
    end
    if (ackf) m_cancel = 1'b0;
    if (old != 0) begin
      if (mem_ack) m_owner = 0;
    end else if (eu_req) begin
      m_owner = 2;
      m_addr  = eu_addr;
      m_we    = eu_we;
    end else if (!flush && nfree >= 2) begin
      m_owner = 1;
      m_addr  = 20'(({4'h0, m_seg} << 4) + {4'h0, m_off});
      m_we    = 1'b0;
    end
    if (flush) begin
      mq.delete();
      if (old == 1 && !mem_ack) m_cancel = 1'b1;
      m_seg = flush_seg;
      m_off = flush_off;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr1 = 1'b0;
      mr2 = 1'b0;
      model_reset();
    end else begin
      if (mr2) model_step();
      mr2 = mr1;
      mr1 = 1'b1;
    end
  end

  // stimulus controls
  int          rdy_pct = 0, eu_pct = 0, fl_pct = 0, lat_max = 0, lat_fix = -1;
  bit          f_flush = 1'b0, f_eu = 1'b0;
  logic [15:0] f_seg, f_off;
  logic [19:0] f_eaddr;
  bit          eu_acked = 1'b0, in_txn = 1'b0;
  int          wait_cnt = 0;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  task automatic compare();
    check("R3 mem_req", mem_req, (m_owner != 0));
    if (m_owner != 0) begin
      check("R2 mem_addr", mem_addr, m_addr);
      check("R11 mem_we", mem_we, m_we);
    end
    check("R10 q_valid", q_valid, (mq.size() > 0));
    if (mq.size() > 0) check("R6 q_data", q_data, mq[0]);
    check("R11 eu_ack", eu_ack, (m_owner == 2) && mem_ack);
  endtask

  task automatic cycle();
    @(negedge clk);
    cyc++;
    if (cyc > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      summary();
      $finish;
    end
    // memory model
    mem_ack = 1'b0;
    if (mem_req) begin
      if (!in_txn) begin
        in_txn   = 1'b1;
        wait_cnt = (lat_fix >= 0) ? lat_fix : int'($urandom % (lat_max + 1));
      end
      if (wait_cnt == 0) begin
        mem_ack   = 1'b1;
        mem_rdata = {byte_at(mem_addr | 20'h1), byte_at(mem_addr & ~20'h1)};
        in_txn    = 1'b0;
      end else begin
        wait_cnt--;
      end
    end
    // flush
    flush = 1'b0;
    if (f_flush) begin
      flush = 1'b1; flush_seg = f_seg; flush_off = f_off; f_flush = 1'b0;
    end else if (int'($urandom % 100) < fl_pct) begin
      flush = 1'b1; flush_seg = 16'($urandom); flush_off = 16'($urandom);
    end
    q_ready = int'($urandom % 100) < rdy_pct;
    // execution-unit requester
    if (eu_req && eu_acked) begin
      eu_req = 1'b0;
    end else if (!eu_req && (f_eu || int'($urandom % 100) < eu_pct)) begin
      eu_req  = 1'b1;
      eu_addr = f_eu ? f_eaddr : 20'($urandom);
      eu_we   = f_eu ? 1'b0 : 1'($urandom);
      f_eu    = 1'b0;
    end
    #1;
    compare();
    eu_acked = eu_ack;
  endtask

  task automatic wait_req();
    int n = 0;
    do begin cycle(); n++; end while (!mem_req && n < 300);
    if (!mem_req) check("R3 request timeout", 0, 1);
  endtask

  task automatic wait_next_req();
    int n = 0;
    while (mem_req && n < 300) begin cycle(); n++; end
    wait_req();
  endtask

  task automatic wait_valid();
    int n = 0;
    while (!q_valid && n < 300) begin cycle(); n++; end
    if (!q_valid) check("R10 valid timeout", 0, 1);
  endtask

  task automatic wait_idle();
    int quiet = 0;
    int n = 0;
    rdy_pct = 0; eu_pct = 0; fl_pct = 0;
    while (quiet < 4 && n < 400) begin
      cycle(); n++;
      quiet = mem_req ? 0 : quiet + 1;
    end
  endtask

  initial begin
    int acks;
    rst_n = 1'b0;
    repeat (3) cycle();
    check("R12 reset mem_req", mem_req, 0);
    check("R12 reset q_valid", q_valid, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    cycle();
    check("R12 still held after release", mem_req, 0);

    // first fetch from reset vector, no pops
    lat_max = 2;
    wait_req();
    check("R2 first fetch address", mem_addr, 20'hFFFF0);

    // depth fill from an even offset
    wait_idle();
    f_flush = 1'b1; f_seg = 16'h2000; f_off = 16'h0100;
    cycle();
    acks = 0;
    repeat (60) begin
      cycle();
      if (mem_req && mem_ack) acks++;
    end
    check("R1 fetches to fill", acks, 3);
    check("R3 no fetch when full", mem_req, 0);
    check("R1 queue holds bytes", q_valid, 1);
    check("R6 head after fill", q_data, byte_at(20'h20100));

    // execution unit and refill eligible together
    f_flush = 1'b1; f_seg = 16'h3000; f_off = 16'h0000;
    cycle();
    f_eu = 1'b1; f_eaddr = 20'h5A5A5;
    cycle();
    cycle();
    check("R4 eu wins bus", mem_req, 1);
    check("R4 eu address", mem_addr, 20'h5A5A5);

    // execution unit waits for in-flight fetch
    wait_idle();
    lat_fix = 5;
    f_flush = 1'b1; f_seg = 16'h0400; f_off = 16'h0000;
    wait_req();
    check("R2 fetch after flush", mem_addr, 20'h04000);
    f_eu = 1'b1; f_eaddr = 20'h12345;
    cycle();
    cycle();
    check("R5 fetch address held", mem_addr, 20'h04000);
    check("R5 fetch not a write", mem_we, 0);
    wait_next_req();
    check("R5 eu served after fetch", mem_addr, 20'h12345);

    // flush during an outstanding fetch
    wait_idle();
    f_flush = 1'b1; f_seg = 16'h0400; f_off = 16'h0000;
    wait_req();
    f_flush = 1'b1; f_seg = 16'h0500; f_off = 16'h0010;
    cycle();
    cycle();
    check("R8 queue empty after flush", q_valid, 0);
    wait_next_req();
    check("R8 new fetch address", mem_addr, 20'h05010);
    wait_valid();
    check("R8 first byte from new stream", q_data, byte_at(20'h05010));
    lat_fix = -1;

    // offset and address wrap
    wait_idle();
    f_flush = 1'b1; f_seg = 16'hFFFF; f_off = 16'hFFFE;
    cycle();
    wait_req();
    check("R9 wrapped address", mem_addr, 20'h0FFEE);
    wait_valid();
    check("R7 even lane first", q_data, byte_at(20'h0FFEE));
    wait_next_req();
    check("R9 offset wrapped to zero", mem_addr, 20'hFFFF0);

    // odd offset fetch
    wait_idle();
    f_flush = 1'b1; f_seg = 16'h1234; f_off = 16'h0011;
    cycle();
    wait_req();
    check("R2 odd fetch address", mem_addr, 20'h12351);
    wait_valid();
    check("R7 odd lane byte", q_data, byte_at(20'h12351));
    wait_next_req();
    check("R7 offset advanced by one", mem_addr, 20'h12352);

    // streaming and random mixes, compared every cycle
    rdy_pct = 100; eu_pct = 0; fl_pct = 0; lat_max = 0;
    repeat (400) cycle();
    rdy_pct = 60; eu_pct = 10; fl_pct = 2; lat_max = 3;
    repeat (4000) cycle();
    rdy_pct = 100; eu_pct = 30; fl_pct = 1; lat_max = 0;
    repeat (2000) cycle();
    rdy_pct = 30; eu_pct = 5; fl_pct = 4; lat_max = 1;
    repeat (2000) cycle();

    summary();
    $finish;
  end
endmodule